// File: doc/BRIEF.md
# Reservoir-Based Channel Occupancy Detector

This block decides, one frame at a time, whether a radio channel carries traffic. Each frame delivers one signed in-phase and one signed quadrature sample over a valid/ready handshake. The block takes the magnitude of the pair with a sequential integer square root and scales it into a signed Q2.14 fixed-point value. It then drives a ring of 50 virtual reservoir nodes. Every node has its own input mask and feeds back its own value from the previous frame. A single nonlinear element serves all the nodes, one node per clock.

A linear readout weighs every new node state and adds a bias. The result is a signed Q2.14 occupancy score, and a busy flag is raised when the score is at least one half. A small address/data/write-enable port loads the masks, the weights and the bias while the core is idle. Weights are trained offline. The node memory holds the reservoir's delayed state from one frame to the next.

Top module: `dfr_classifier`

## Requirements
- R1: `inReady` is high only while the core is idle. A pair is taken on a rising edge where `inValid` and `inReady` are both high. `inReady` then stays low until the cycle after the `outValid` pulse.
- R2: `outValid` is a one-cycle pulse. It rises on the 68th rising edge after the accepting edge: 17 square-root steps, then 50 node steps, then 1 readout step.
- R3: The magnitude is floor(sqrt(I*I + Q*Q)), a 17-bit unsigned value. The reservoir input u is that magnitude shifted right by one bit and read as Q2.14 (16384 = 1.0).
- R4: Node i gets x_i = f(floor(m_i*u / 2^15) + floor(x_i_prev*6554 / 2^14)). This is gain 0.5 on the masked input and 0.4 on the feedback. f clamps its argument to [-16384, 16384].
- R5: Each node's state from one frame is its feedback term in the next frame. All node states are zero after reset.
- R6: The score is sat16(floor(sum of w_i*x_i / 2^14) + bias). All 50 new node states are summed, and sat16 clamps to [-32768, 32767].
- R7: `busy` is 1 exactly when the signed score is at least 8192 (0.5).
- R8: Configuration map: with address bit 6 = 0, bits 5..0 select mask 0..49. With bit 6 = 1, bits 5..0 select weight 0..49, and 50 selects the bias. Any other address is ignored.
- R9: A mask value written outside [-8192, 8192] is stored saturated to the nearer bound.
- R10: A configuration write while the core is not idle has no effect.
- R11: After reset `inReady` = 1, `outValid` = 0, `score` = 0 and `busy` = 0. Every mask, weight and the bias are zero.
- R12: `score` and `busy` hold their values between `outValid` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Sample pair offered |
| inReady | output | 1 | Core idle, pair can be taken |
| inI | input | 16 | In-phase sample, signed |
| inQ | input | 16 | Quadrature sample, signed |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 7 | Configuration address |
| cfgData | input | 16 | Configuration value, signed Q2.14 |
| outValid | output | 1 | One-cycle result strobe |
| score | output | 16 | Occupancy score, signed Q2.14 |
| busy | output | 1 | Channel judged occupied |

## Verification
A frame's results are due 68 rising edges after it is accepted. That is 17 root steps, 50 node steps and one readout step, and `inReady` comes back one edge later. The bench drives on falling edges. It counts falling edges from the accepting edge until `outValid` is seen, and compares that count with 68 before it compares `score` and `busy` with its own frame model. The pulse width and the return of `inReady` are then checked at the next falling edge. The configuration write that R10 says must be ignored is issued on the fifth edge of a running frame. Its absence is then shown through a later frame's score.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ROOT,
    PH_NODE,
    PH_SUM,
    PH_DONE
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic idle;
    logic accept;
    logic rootStep;
    logic nodeStep;
    logic finish;
  } dfrStrobe_t;

endpackage

// File: rtl/dfr_ctrl.sv
module dfr_ctrl
  import dfr_pkg::*;
#(
  parameter int NODES  = 50,
  parameter int ROOT_W = 17,
  parameter int CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  output logic             outValid,
  output dfrStrobe_t       strobe,
  output logic [CNT_W-1:0] cnt
);

  phase_t phase;

  // one counter serves as bit index while rooting and node index afterwards
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (inValid) begin
            phase <= PH_ROOT;
            cnt   <= CNT_W'(ROOT_W - 1);
          end
        end
        PH_ROOT: begin
          if (cnt == '0) phase <= PH_NODE;
          else           cnt   <= cnt - 1'b1;
        end
        PH_NODE: begin
          if (cnt == CNT_W'(NODES - 1)) begin
            phase <= PH_SUM;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_SUM:  phase <= PH_DONE;
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.idle     = (phase == PH_IDLE);
    strobe.accept   = (phase == PH_IDLE) && inValid;
    strobe.rootStep = (phase == PH_ROOT);
    strobe.nodeStep = (phase == PH_NODE);
    strobe.finish   = (phase == PH_SUM);
  end

  assign inReady  = (phase == PH_IDLE);
  assign outValid = (phase == PH_DONE);

  // R2: the node sweep starts at node zero right after the last root step
  a_r2_sweep_start: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ROOT && cnt == '0) |=> (phase == PH_NODE && cnt == '0));

  // R2: the readout step follows the last node
  a_r2_sweep_end: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_NODE && cnt == CNT_W'(NODES - 1)) |=> (phase == PH_SUM));

endmodule

// File: rtl/dfr_datapath.sv
module dfr_datapath
  import dfr_pkg::*;
#(
  parameter int NODES     = 50,
  parameter int SAMPLE_W  = 16,
  parameter int FRAC      = 14,
  parameter int MAG_SHIFT = 1,
  parameter int IN_SHIFT  = 15,
  parameter int FB_COEF   = 6554,
  parameter int ACC_W     = 40,
  parameter int ROOT_W    = 17,
  parameter int SUM_W     = 33,
  parameter int CNT_W     = 6,
  parameter int ADDR_W    = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dfrStrobe_t                 strobe,
  input  logic [CNT_W-1:0]           cnt,
  input  logic signed [SAMPLE_W-1:0] inI,
  input  logic signed [SAMPLE_W-1:0] inQ,
  input  logic                       cfgWe,
  input  logic [ADDR_W-1:0]          cfgAddr,
  input  logic signed [SAMPLE_W-1:0] cfgData,
  output logic signed [SAMPLE_W-1:0] score,
  output logic                       busy
);

  localparam int PROD_W = 2 * SAMPLE_W;
  localparam int IDX_W  = ADDR_W - 1;
  localparam logic signed [PROD_W-1:0]   ONE_P    = PROD_W'(1) <<< FRAC;
  localparam logic signed [SAMPLE_W-1:0] ONE_S    = SAMPLE_W'(1) <<< FRAC;
  localparam logic signed [SAMPLE_W-1:0] HALF_S   = SAMPLE_W'(1) <<< (FRAC - 1);
  localparam logic signed [SAMPLE_W-1:0] FB_K     = SAMPLE_W'(FB_COEF);
  localparam logic signed [ACC_W-1:0]    SAT_HI   = ACC_W'((1 << (SAMPLE_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0]    SAT_LO   = -ACC_W'(1 << (SAMPLE_W - 1));

  logic signed [SAMPLE_W-1:0] maskMem  [NODES];
  logic signed [SAMPLE_W-1:0] weightMem[NODES+1];
  logic signed [SAMPLE_W-1:0] stateMem [NODES];

  logic [SUM_W-1:0]         sumSq;
  logic [ROOT_W-1:0]        root;
  logic signed [ACC_W-1:0]  acc;

  // ---------------- configuration port ----------------
  logic             cfgRegion;
  logic [IDX_W-1:0] cfgIdx;
  logic signed [SAMPLE_W-1:0] maskSat;

  assign cfgRegion = cfgAddr[ADDR_W-1];
  assign cfgIdx    = cfgAddr[IDX_W-1:0];

  always_comb begin
    if (cfgData > HALF_S)       maskSat = HALF_S;
    else if (cfgData < -HALF_S) maskSat = -HALF_S;
    else                        maskSat = cfgData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NODES; i++) maskMem[i] <= '0;
      for (int i = 0; i <= NODES; i++) weightMem[i] <= '0;
    end else if (cfgWe && strobe.idle) begin
      if (!cfgRegion && (int'(cfgIdx) < NODES))
        maskMem[cfgIdx] <= maskSat;
      else if (cfgRegion && (int'(cfgIdx) <= NODES))
        weightMem[cfgIdx] <= cfgData;
    end
  end

  // ---------------- magnitude front end ----------------
  logic signed [PROD_W-1:0] sqI, sqQ;
  logic [ROOT_W-1:0]        trial;
  logic [2*ROOT_W-1:0]      trialSq;

  assign sqI     = inI * inI;
  assign sqQ     = inQ * inQ;
  assign trial   = root | (ROOT_W'(1) << cnt);
  assign trialSq = (2*ROOT_W)'(trial) * (2*ROOT_W)'(trial);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumSq <= '0;
      root  <= '0;
    end else if (strobe.accept) begin
      sumSq <= SUM_W'($unsigned(sqI)) + SUM_W'($unsigned(sqQ));
      root  <= '0;
    end else if (strobe.rootStep) begin
      if (trialSq <= (2*ROOT_W)'(sumSq)) root <= trial;
    end
  end

  // ---------------- shared nonlinear node ----------------
  logic signed [SAMPLE_W-1:0] uVal;
  logic signed [SAMPLE_W-1:0] xPrev, xNew;
  logic signed [PROD_W-1:0]   maskProd, fbProd, inTerm, fbTerm, preAct, wProd;

  assign uVal     = SAMPLE_W'(root >> MAG_SHIFT);
  assign xPrev    = stateMem[cnt];
  assign maskProd = maskMem[cnt] * uVal;
  assign fbProd   = xPrev * FB_K;
  assign inTerm   = maskProd >>> IN_SHIFT;
  assign fbTerm   = fbProd >>> FRAC;
  assign preAct   = inTerm + fbTerm;

  always_comb begin
    if (preAct > ONE_P)       xNew = ONE_S;
    else if (preAct < -ONE_P) xNew = -ONE_S;
    else                      xNew = SAMPLE_W'(preAct);
  end

  assign wProd = weightMem[cnt] * xNew;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NODES; i++) stateMem[i] <= '0;
    end else if (strobe.nodeStep) begin
      stateMem[cnt] <= xNew;
    end
  end

  // ---------------- linear readout ----------------
  logic signed [ACC_W-1:0]    scoreWide;
  logic signed [SAMPLE_W-1:0] scoreSat;

  assign scoreWide = (acc >>> FRAC) + ACC_W'(weightMem[NODES]);

  always_comb begin
    if (scoreWide > SAT_HI)      scoreSat = SAMPLE_W'(SAT_HI);
    else if (scoreWide < SAT_LO) scoreSat = SAMPLE_W'(SAT_LO);
    else                         scoreSat = SAMPLE_W'(scoreWide);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc   <= '0;
      score <= '0;
      busy  <= 1'b0;
    end else begin
      if (strobe.accept)        acc <= '0;
      else if (strobe.nodeStep) acc <= acc + ACC_W'(wProd);
      if (strobe.finish) begin
        score <= scoreSat;
        busy  <= (scoreSat >= HALF_S);
      end
    end
  end

  // R3: the finished root is the floor of the square root
  a_r3_root_floor: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.nodeStep && cnt == '0) |->
      (((2*ROOT_W+1)'(root) * (2*ROOT_W+1)'(root) <= (2*ROOT_W+1)'(sumSq)) &&
       (((2*ROOT_W+1)'(root) + 1) * ((2*ROOT_W+1)'(root) + 1) > (2*ROOT_W+1)'(sumSq))));

  // R4: any state read back as feedback lies inside the clamp range
  a_r4_feedback_bounded: assert property (@(posedge clk) disable iff (!rstN)
    strobe.nodeStep |-> (xPrev <= ONE_S && xPrev >= -ONE_S));

  // R9: every stored mask stays within plus or minus one half
  a_r9_mask_bounded: assert property (@(posedge clk) disable iff (!rstN)
    strobe.nodeStep |-> (maskMem[cnt] <= HALF_S && maskMem[cnt] >= -HALF_S));

endmodule

// File: rtl/dfr_classifier.sv
module dfr_classifier
  import dfr_pkg::*;
#(
  parameter int NODES     = 50,
  parameter int SAMPLE_W  = 16,
  parameter int FRAC      = 14,
  parameter int MAG_SHIFT = 1,
  parameter int IN_SHIFT  = 15,
  parameter int FB_COEF   = 6554,
  parameter int ACC_W     = 40,
  parameter int ADDR_W    = $clog2(NODES + 1) + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  output logic                       inReady,
  input  logic signed [SAMPLE_W-1:0] inI,
  input  logic signed [SAMPLE_W-1:0] inQ,
  input  logic                       cfgWe,
  input  logic [ADDR_W-1:0]          cfgAddr,
  input  logic signed [SAMPLE_W-1:0] cfgData,
  output logic                       outValid,
  output logic signed [SAMPLE_W-1:0] score,
  output logic                       busy
);

  localparam int ROOT_W = SAMPLE_W + 1;
  localparam int SUM_W  = 2 * SAMPLE_W + 1;
  localparam int CNT_W  = $clog2((NODES > ROOT_W) ? NODES : ROOT_W);

  dfrStrobe_t       strobe;
  logic [CNT_W-1:0] cnt;

  dfr_ctrl #(
    .NODES(NODES), .ROOT_W(ROOT_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inReady(inReady), .outValid(outValid),
    .strobe(strobe), .cnt(cnt)
  );

  dfr_datapath #(
    .NODES(NODES), .SAMPLE_W(SAMPLE_W), .FRAC(FRAC), .MAG_SHIFT(MAG_SHIFT),
    .IN_SHIFT(IN_SHIFT), .FB_COEF(FB_COEF), .ACC_W(ACC_W), .ROOT_W(ROOT_W),
    .SUM_W(SUM_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cnt(cnt),
    .inI(inI), .inQ(inQ),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .score(score), .busy(busy)
  );

  // R1: a result is never presented while new input is being taken
  a_r1_no_ready_on_valid: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  // R2: the result strobe lasts a single cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R12: outputs change only together with a fresh result strobe
  a_r12_score_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(outValid) |-> ($stable(score) && $stable(busy)));

endmodule

// File: tb/sim_dfr_classifier.sv
module sim_dfr_classifier;

  localparam int CLK_PERIOD = 10;
  localparam int NN         = 50;
  localparam int LATENCY    = 17 + 50 + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [15:0] inI = '0, inQ = '0;
  logic cfgWe = 1'b0;
  logic [6:0] cfgAddr = '0;
  logic signed [15:0] cfgData = '0;
  logic inReady, outValid, busy;
  logic signed [15:0] score;

  int nChk = 0;
  int nFail = 0;

  longint mk[NN];
  longint wt[NN+1];
  longint st[NN];

  always #(CLK_PERIOD/2) clk = ~clk;

  dfr_classifier u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inI(inI), .inQ(inQ), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .outValid(outValid), .score(score), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint isqrt(input longint s);
    longint r;
    r = longint'($floor($sqrt(real'(s))));
    while (r * r > s) r--;
    while ((r + 1) * (r + 1) <= s) r++;
    return r;
  endfunction

  // model of one frame from the requirements; updates node states
  task automatic model(input longint i, input longint q, output longint sc, output bit b);
    longint mag, u, acc, p;
    mag = isqrt(i * i + q * q);
    u = mag >>> 1;
    acc = 0;
    for (int n = 0; n < NN; n++) begin
      p = ((mk[n] * u) >>> 15) + ((st[n] * 6554) >>> 14);
      if (p > 16384) p = 16384;
      if (p < -16384) p = -16384;
      st[n] = p;
      acc += wt[n] * p;
    end
    sc = (acc >>> 14) + wt[NN];
    if (sc > 32767) sc = 32767;
    if (sc < -32768) sc = -32768;
    b = (sc >= 8192);
  endtask

  task automatic cfg(input int addr, input longint data);
    int idx;
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 7'(addr); cfgData = 16'(data);
    @(negedge clk);
    cfgWe = 1'b0;
    idx = addr & 63;
    if (addr < 64 && idx < NN) mk[idx] = (data > 8192) ? 8192 : ((data < -8192) ? -8192 : data);
    else if (addr >= 64 && idx <= NN) wt[idx] = data;
  endtask

  task automatic frame(input longint i, input longint q, input string tag,
                       input bit doMid, input int midAddr, input longint midData);
    longint esc;
    bit eb;
    int n;
    model(i, q, esc, eb);
    @(negedge clk);
    chk(inReady == 1'b1, "R1 ready before frame", inReady, 1);
    inValid = 1'b1; inI = 16'(i); inQ = 16'(q);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    n = 0;
    while (!outValid && n < 200) begin
      if (n == 30) chk(inReady == 1'b0, "R1 ready low mid frame", inReady, 0);
      if (doMid && n == 5) begin
        cfgWe = 1'b1; cfgAddr = 7'(midAddr); cfgData = 16'(midData);
      end
      if (n == 6) cfgWe = 1'b0;
      @(negedge clk);
      n++;
    end
    chk(n == LATENCY, "R2 latency", n, LATENCY);
    chk(score == 16'(esc), {tag, " score"}, score, esc);
    chk(busy == eb, {tag, " busy"}, busy, eb);
    @(negedge clk);
    chk(outValid == 1'b0, "R2 single cycle pulse", outValid, 0);
    chk(inReady == 1'b1, "R1 ready returns", inReady, 1);
  endtask

  task automatic t_reset();
    chk(inReady == 1'b1, "R11 reset inReady", inReady, 1);
    chk(outValid == 1'b0, "R11 reset outValid", outValid, 0);
    chk(score == 0, "R11 reset score", score, 0);
    chk(busy == 1'b0, "R11 reset busy", busy, 0);
    frame(12000, -7000, "R11 zero coefficients", 1'b0, 0, 0);
  endtask

  task automatic t_magnitude();
    cfg(0, 8192);
    cfg(64, 16384);
    frame(3000, 4000, "R3 magnitude 3-4-5", 1'b0, 0, 0);
    frame(-32768, -32768, "R3 magnitude extreme", 1'b0, 0, 0);
    frame(0, -32768, "R3 magnitude axis", 1'b0, 0, 0);
  endtask

  task automatic t_feedback();
    frame(30000, 0, "R5 charge", 1'b0, 0, 0);
    frame(0, 0, "R5 decay one", 1'b0, 0, 0);
    frame(0, 0, "R5 decay two", 1'b0, 0, 0);
  endtask

  task automatic t_patterns();
    for (int n = 0; n < NN; n++) begin
      cfg(n, ((n * 1237) % 16385) - 8192);
      cfg(64 + n, ((n * 977) % 9000) - 3000);
    end
    cfg(64 + NN, 2000);
    frame(20000, -15000, "R4 pattern A", 1'b0, 0, 0);
    frame(-123, 31000, "R4 pattern B", 1'b0, 0, 0);
    frame(-32768, 32767, "R6 pattern C", 1'b0, 0, 0);
    frame(5, -5, "R6 pattern D", 1'b0, 0, 0);
  endtask

  task automatic t_mask_sat();
    cfg(3, 30000);
    frame(25000, 25000, "R9 positive mask clamp", 1'b0, 0, 0);
    cfg(3, -30000);
    frame(25000, 25000, "R9 negative mask clamp", 1'b0, 0, 0);
  endtask

  task automatic t_addr_map();
    // index 50 in mask space and 51 in weight space select nothing
    cfg(50, 8000);
    cfg(64 + 51, 30000);
    cfg(63, -8000);
    frame(-20000, 9000, "R8 unused addresses", 1'b0, 0, 0);
    cfg(64 + NN, -1000);
    frame(-20000, 9000, "R8 bias slot", 1'b0, 0, 0);
  endtask

  task automatic t_locked();
    // mid-frame writes to bias and mask 0 must be dropped
    frame(10000, 10000, "R10 write during frame", 1'b1, 64 + NN, 20000);
    frame(10000, 10000, "R10 bias unchanged", 1'b1, 0, -8192);
    frame(10000, 10000, "R10 mask unchanged", 1'b0, 0, 0);
  endtask

  task automatic t_threshold();
    for (int n = 0; n < NN; n++) cfg(64 + n, 0);
    cfg(64 + NN, 8192);
    frame(1000, 1000, "R7 at threshold", 1'b0, 0, 0);
    cfg(64 + NN, 8191);
    frame(1000, 1000, "R7 below threshold", 1'b0, 0, 0);
    cfg(64 + NN, -20000);
    frame(1000, 1000, "R7 negative score", 1'b0, 0, 0);
  endtask

  task automatic t_saturate();
    cfg(0, 8192);
    cfg(64, 32767);
    cfg(64 + NN, 32767);
    frame(32767, 32767, "R6 positive saturation", 1'b0, 0, 0);
    cfg(64, -32768);
    cfg(64 + NN, -32768);
    frame(32767, 32767, "R6 negative saturation", 1'b0, 0, 0);
  endtask

  task automatic t_hold();
    logic signed [15:0] s0;
    logic b0;
    cfg(64 + NN, 9000);
    frame(0, 0, "R12 setup", 1'b0, 0, 0);
    s0 = score; b0 = busy;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      inI = 16'(k * 1000); inQ = 16'(-k * 500);
    end
    chk(score == s0, "R12 score holds", score, s0);
    chk(busy == b0, "R12 busy holds", busy, b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    for (int n = 0; n < NN; n++) begin mk[n] = 0; wt[n] = 0; st[n] = 0; end
    wt[NN] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_magnitude();
    t_feedback();
    t_patterns();
    t_mask_sat();
    t_addr_map();
    t_locked();
    t_threshold();
    t_saturate();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule